// File: doc/BRIEF.md
# Gated Event-Per-Period Rate Meter

This block measures how many event pulses arrive within a programmable number of time-base ticks. Event pulses and tick pulses come in on separate asynchronous pins. Each pin passes through a two-stage synchronizer and a rising-edge detector. A detected edge sets a one-deep sticky flag for that pin. A single controller services one pending flag per clock cycle. A serviced tick lowers a unit-time countdown, and a serviced event raises an event counter.

When the countdown is used up, the controller ends the counting period in this order:
1. It copies the event count into the display register.
2. It pulses a period-done strobe for one cycle.
3. It zeroes the event counter.
4. It reloads the countdown from the switch input.

An optional guard interval of a programmable number of clock cycles can separate periods. Events that arrive during the guard are discarded. Because each flag holds only one pulse, closely spaced pulses can be lost. Each pin therefore has a sticky overrun indicator, which software-free logic or a supervisor can clear.

The display is a plain registered value and the strobe is a single-cycle pulse. There is no back-pressure: a consumer samples `disp_count` when `period_done` is high, or at any time afterwards, until the next strobe.

Top module: `rate_meter`

## Requirements
- R1: After reset, `disp_count` is 0, and `period_done`, `evt_overrun` and `tick_overrun` are all low.
- R2: A counting period ends on the N-th serviced tick after it starts. N is the value of `switch_val` at the moment the period starts, meaning at the end of the previous period or on leaving reset. Fewer ticks never end a period.
- R3: At a period end, `disp_count` takes the number of events serviced during that period as a plain unsigned binary value. The event counter then restarts from zero. `disp_count` changes at no other time.
- R4: `period_done` is high for exactly one cycle each time `disp_count` is updated, and never for two cycles in a row.
- R5: A `switch_val` of 0 gives a period of one tick.
- R6: When a tick and an event are pending together, the tick is serviced first. If that tick ends the period, the event is counted in the next period.
- R7: When `guard_en` is 1, a guard of `guard_len` clock cycles (minimum 1) follows each period end. Events that arrive during the guard are discarded and are never counted. Ticks that arrive during the guard stay pending and are serviced after it.
- R8: `evt_overrun` or `tick_overrun` goes high when a new edge arrives on that pin while its flag is still pending and not being serviced. The bit stays high until `ovr_clr` is asserted.
- R9: An input that stays high for many cycles counts as one pulse, because only rising edges are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Asynchronous event pulse |
| tick_in | input | 1 | Asynchronous time-base tick pulse |
| switch_val | input | TW (16) | Number of ticks per period (0 acts as 1) |
| guard_en | input | 1 | Enables the guard interval between periods |
| guard_len | input | GW (8) | Guard length in clock cycles (0 acts as 1) |
| ovr_clr | input | 1 | Clears both overrun bits |
| disp_count | output | CW (16) | Event count of the last finished period |
| period_done | output | 1 | One-cycle strobe when `disp_count` updates |
| evt_overrun | output | 1 | Sticky: an event pulse was lost |
| tick_overrun | output | 1 | Sticky: a tick pulse was lost |

## Verification
The random part of the bench builds periods of 1 to 4 ticks and mixes events and ticks in random order. After every tick the bench checks whether a period should have ended, so both an early end and a missing end are caught. Directed patterns cover the following cases:
- A long high pulse, which separates edge counting from level counting.
- A zero switch value, which shows the countdown never stalls.
- A tick and an event in the same cycle, which shows the service order and which period the event lands in.
- A guard interval that receives two events and two ticks. This shows that events are discarded while ticks are held, that both overrun bits latch, and that the clear input resets them.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_GUARD = 2'd2
  } rm_state_e;
endpackage

// File: rtl/rm_capture.sv
module rm_capture #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  input  logic svc_clr,
  input  logic ovr_clr,
  output logic flag,
  output logic overrun
);
  logic [SYNC:0] sh_q;
  logic          rise;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC-1:0], pulse_in};
  end

  assign rise = sh_q[SYNC-1] & ~sh_q[SYNC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      flag    <= rise | (flag & ~svc_clr);
      overrun <= (overrun & ~ovr_clr) | (rise & flag & ~svc_clr);
    end
  end
endmodule

// File: rtl/rm_ctrl.sv
module rm_ctrl
  import rm_pkg::*;
#(
  parameter int CW = 16,
  parameter int TW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_flag,
  input  logic          evt_flag,
  input  logic [TW-1:0] switch_val,
  input  logic          guard_en,
  input  logic [GW-1:0] guard_len,
  output logic          tick_clr,
  output logic          evt_clr,
  output logic [CW-1:0] disp_count,
  output logic          period_done
);
  rm_state_e     state_q;
  logic [TW-1:0] ut_q;
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] gcnt_q;
  logic [TW-1:0] reload;
  logic [GW-1:0] guard_init;
  logic          guard_last;

  assign reload     = (switch_val == '0) ? TW'(1) : switch_val;
  assign guard_init = (guard_len == '0) ? GW'(1) : guard_len;
  assign guard_last = (state_q == ST_GUARD) && (gcnt_q == GW'(1));

  always_comb begin
    tick_clr = (state_q == ST_COUNT) && tick_flag;
    evt_clr  = ((state_q == ST_COUNT) && !tick_flag && evt_flag) || guard_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_LOAD;
      ut_q        <= '0;
      cnt_q       <= '0;
      gcnt_q      <= '0;
      disp_count  <= '0;
      period_done <= 1'b0;
    end else begin
      period_done <= 1'b0;
      unique case (state_q)
        ST_LOAD: begin
          ut_q    <= reload;
          state_q <= ST_COUNT;
        end
        ST_COUNT: begin
          if (tick_flag) begin
            if (ut_q == TW'(1)) begin
              disp_count  <= cnt_q;
              period_done <= 1'b1;
              cnt_q       <= '0;
              if (guard_en) begin
                gcnt_q  <= guard_init;
                state_q <= ST_GUARD;
              end else begin
                ut_q <= reload;
              end
            end else begin
              ut_q <= ut_q - TW'(1);
            end
          end else if (evt_flag) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_GUARD: begin
          if (guard_last) begin
            ut_q    <= reload;
            state_q <= ST_COUNT;
          end else begin
            gcnt_q <= gcnt_q - GW'(1);
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/rate_meter.sv
module rate_meter #(
  parameter int CW   = 16,
  parameter int TW   = 16,
  parameter int GW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_in,
  input  logic          tick_in,
  input  logic [TW-1:0] switch_val,
  input  logic          guard_en,
  input  logic [GW-1:0] guard_len,
  input  logic          ovr_clr,
  output logic [CW-1:0] disp_count,
  output logic          period_done,
  output logic          evt_overrun,
  output logic          tick_overrun
);
  logic tick_flag, evt_flag, tick_clr, evt_clr;

  rm_capture #(.SYNC(SYNC)) u_tick_cap (
    .clk(clk), .rst_n(rst_n), .pulse_in(tick_in), .svc_clr(tick_clr),
    .ovr_clr(ovr_clr), .flag(tick_flag), .overrun(tick_overrun)
  );

  rm_capture #(.SYNC(SYNC)) u_evt_cap (
    .clk(clk), .rst_n(rst_n), .pulse_in(evt_in), .svc_clr(evt_clr),
    .ovr_clr(ovr_clr), .flag(evt_flag), .overrun(evt_overrun)
  );

  rm_ctrl #(.CW(CW), .TW(TW), .GW(GW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_flag(tick_flag), .evt_flag(evt_flag),
    .switch_val(switch_val), .guard_en(guard_en), .guard_len(guard_len),
    .tick_clr(tick_clr), .evt_clr(evt_clr), .disp_count(disp_count),
    .period_done(period_done)
  );
endmodule

// File: rtl/rm_checker.sv
module rm_checker
  import rm_pkg::*;
#(
  parameter int CW = 16,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ovr_clr,
  input logic [CW-1:0] disp_count,
  input logic          period_done,
  input logic          evt_overrun,
  input logic          tick_overrun,
  input rm_state_e     state,
  input logic [TW-1:0] ut,
  input logic [CW-1:0] cnt
);
  p_disp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_done |-> $stable(disp_count));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_done |=> !period_done);

  p_ut_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT) |-> (ut != '0));

  p_guard_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GUARD) |-> (cnt == '0));

  p_evt_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_overrun && !ovr_clr) |=> evt_overrun);

  p_tick_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_overrun && !ovr_clr) |=> tick_overrun);
endmodule

bind rate_meter rm_checker #(.CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovr_clr(ovr_clr), .disp_count(disp_count),
  .period_done(period_done), .evt_overrun(evt_overrun),
  .tick_overrun(tick_overrun), .state(u_ctrl.state_q), .ut(u_ctrl.ut_q),
  .cnt(u_ctrl.cnt_q)
);

// File: tb/sim_rate_meter.sv
module sim_rate_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_in = 1'b0, tick_in = 1'b0, guard_en = 1'b0, ovr_clr = 1'b0;
  logic [15:0] switch_val = 16'd3;
  logic [7:0]  guard_len = 8'd60;
  logic [15:0] disp_count;
  logic        period_done, evt_overrun, tick_overrun;

  int checks = 0, failures = 0;
  int done_cnt = 0, wide_err = 0;
  logic done_prev = 1'b0;
  int ev = 0, tk = 0, cur_n = 3, exp_disp = 0;
  bit ended = 0, finished = 0;

  always #10 clk = ~clk;

  rate_meter u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .tick_in(tick_in),
    .switch_val(switch_val), .guard_en(guard_en), .guard_len(guard_len),
    .ovr_clr(ovr_clr), .disp_count(disp_count), .period_done(period_done),
    .evt_overrun(evt_overrun), .tick_overrun(tick_overrun)
  );

  always @(posedge clk) begin
    if (period_done) done_cnt <= done_cnt + 1;
    if (period_done && done_prev) wide_err <= wide_err + 1;
    done_prev <= period_done;
  end

  function automatic int reload_of(int s);
    return (s == 0) ? 1 : s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_evt();
    evt_in = 1'b1; wait_cyc(2); evt_in = 1'b0; wait_cyc(8);
    ev++;
  endtask

  task automatic tick_model();
    tk++;
    ended = (tk == cur_n);
    if (ended) begin
      exp_disp = ev; ev = 0; tk = 0;
      cur_n = reload_of(int'(switch_val));
    end
  endtask

  task automatic send_tick();
    int d0 = done_cnt;
    tick_in = 1'b1; wait_cyc(2); tick_in = 1'b0; wait_cyc(8);
    tick_model();
    check("R2 done count", done_cnt, ended ? d0 + 1 : d0);
    if (ended) check("R3 display", int'(disp_count), exp_disp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    // R1 reset state
    check("R1 disp", int'(disp_count), 0);
    check("R1 done", int'(period_done), 0);
    check("R1 evt_ovr", int'(evt_overrun), 0);
    check("R1 tick_ovr", int'(tick_overrun), 0);

    // R2 R3 random periods, guard off
    for (int p = 0; p < 8; p++) begin
      switch_val = 16'($urandom_range(1, 4));
      ended = 0;
      while (!ended) begin
        if ($urandom_range(0, 2) == 0) send_tick();
        else send_evt();
      end
    end

    // R9 held-high event counts once
    evt_in = 1'b1; wait_cyc(30); evt_in = 1'b0; wait_cyc(8);
    ev++;
    ended = 0;
    while (!ended) send_tick();
    check("R9 held input single count", int'(disp_count), exp_disp);

    // R5 zero switch: one-tick periods
    switch_val = 16'd0;
    ended = 0;
    while (!ended) send_tick();
    send_evt();
    send_tick();
    check("R5 one-tick period ended", int'(ended), 1);

    // R6 tick and event in the same cycle: tick first, event to next period
    tick_in = 1'b1; evt_in = 1'b1; wait_cyc(2);
    tick_in = 1'b0; evt_in = 1'b0; wait_cyc(8);
    tick_model();
    ev++;
    check("R6 event not in ending period", int'(disp_count), 0);
    send_tick();
    check("R6 event in next period", int'(disp_count), 1);

    // R7 R8 guard: events discarded, ticks held, overruns latch
    guard_en = 1'b1;
    begin
      int d0;
      send_tick();              // ends period, guard starts
      d0 = done_cnt;
      send_evt(); send_evt();   // inside guard: discarded, second overruns
      ev = 0;
      tick_in = 1'b1; wait_cyc(2); tick_in = 1'b0; wait_cyc(8);
      tick_in = 1'b1; wait_cyc(2); tick_in = 1'b0; wait_cyc(8);
      check("R7 no period end during guard", done_cnt, d0);
      wait_cyc(80);
      check("R7 held tick ends period after guard", done_cnt, d0 + 1);
      check("R7 guard events ignored", int'(disp_count), 0);
      check("R8 evt overrun", int'(evt_overrun), 1);
      check("R8 tick overrun", int'(tick_overrun), 1);
      wait_cyc(80);
      ovr_clr = 1'b1; wait_cyc(1); ovr_clr = 1'b0; wait_cyc(2);
      check("R8 evt overrun cleared", int'(evt_overrun), 0);
      check("R8 tick overrun cleared", int'(tick_overrun), 0);
    end
    guard_en = 1'b0;
    ev = 0; tk = 0; cur_n = 1;
    send_evt(); send_evt();
    send_tick();
    check("R3 count after guard", int'(disp_count), 2);

    check("R4 strobe single cycle", wide_err, 0);
    finish_run();
  end
endmodule